// File: doc/BRIEF.md
# Sequential Floating-Point Add/Subtract Unit

This unit adds or subtracts two floating-point words. Each word holds a 7-bit exponent field, biased by 64, and a 41-bit two's-complement mantissa made of a sign bit and 40 fraction bits. The mantissa value is the signed mantissa divided by 2^40, so it lies in [-1, 1). A pulse on `start_i` captures an accumulator word, an operand word, an operation code and a normalize-enable flag. The unit then works one step per clock.

First it aligns the exponents. The mantissa with the smaller exponent moves right one bit per clock. The bits shifted out go into a 40-bit low extension, and copies of the sign bit fill the top. Next it adds the two aligned mantissas by repeated carry settling: each clock forms the XOR sum and a shifted AND carry, until no carry is left. If the sum has grown past the sign position, the unit shifts it right once and raises the exponent by one. When normalization is enabled, it then shifts left one bit per clock until the two top bits differ or the exponent field reaches zero. A zero mantissa therefore always runs down to exponent field zero.

The 80-bit result splits into two parts. The upper 40 bits, with the sign and the exponent, go to the accumulator output. The lower 40 bits go to the extension output. A cycle counter shows how many clocks the last operation took. Integer addition uses equal exponents with normalization off, so only the carry-settling phase does any work.

Top module: `fpadd_seq`

## Requirements
- R1: After reset, `acc_o`, `ext_o` and `cycles_o` are zero, and `done_o` and `trap_o` are low.
- R2: `op_i` selects the operation: 0 gives acc+opnd, 1 gives acc-opnd, 2 gives opnd-acc, 3 gives |acc|-|opnd|. The word layout is exponent in bits [47:41] and mantissa in bits [40:0], with bit 40 as the sign.
- R3: Alignment takes one clock per unit of exponent difference, plus one clock to finish. The shifted mantissa keeps its sign in the top bits, and its shifted-out bits appear in `ext_o`.
- R4: The add phase takes one clock per carry-settling round, plus one clock to finish.
- R5: With normalization on, the result shifts left one bit per clock until mantissa bit 40 differs from bit 39, or until the exponent field is 0. A zero mantissa always ends with exponent field 0.
- R6: With normalization off, the result is written unnormalized. Equal exponents with normalization off take 4 clocks plus one per carry round.
- R7: A sum outside [-1, 1) is shifted right once and its exponent field is raised by one.
- R8: If a shift of R7 would raise the exponent field past 127, `trap_o` pulses with `done_o`, and `acc_o` and `ext_o` stay unchanged.
- R9: `cycles_o` equals the total number of clocks in the sum of the alignment, add, overflow-fix, normalization and write phases. Adding zeros with exponent fields 127 and 0 takes 259 clocks.
- R10: `done_o` is a single-cycle pulse. `acc_o` changes only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; ignored while busy |
| op_i | input | 2 | Operation code (R2) |
| norm_en_i | input | 1 | Enable left normalization |
| acc_i | input | 48 | Accumulator word operand |
| opnd_i | input | 48 | Second operand word |
| acc_o | output | 48 | Result: exponent and upper mantissa |
| ext_o | output | 40 | Result: lower 40 mantissa bits |
| done_o | output | 1 | Operation finished (one-cycle pulse) |
| trap_o | output | 1 | Exponent overflow, result discarded |
| cycles_o | output | 10 | Clocks used by the last operation |

## Verification
The assertions check four things on every cycle. `done_o` is a one-cycle pulse. A trap always comes with `done_o` and leaves the result registers unchanged. The accumulator output changes only on completion. Every normalized result ends either with its top mantissa bits differing or with exponent field zero.

Only the bench's scenarios can show the rest: that the result values are exact, and that the latency matches the phase counts for each input pattern. The bench covers all four operations, long alignments with sign replication into the extension, a zero operand pair taking the 259-clock path, mantissa overflow, and the trap at the top exponent.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ALIGN, S_ADD, S_FIX, S_NORM, S_WRITE
    } state_e;

    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_SUB    = 2'd1,
        OP_RSUB   = 2'd2,
        OP_ABSSUB = 2'd3
    } op_e;
endpackage

// File: rtl/fpadd_prep.sv
// Widens both mantissas to the working width and applies the sign
// handling that the operation code asks for (R2).
module fpadd_prep #(
    parameter int EXP_W = 7,
    parameter int MAN_W = 40,
    localparam int WORD_W = EXP_W + 1 + MAN_W,
    localparam int WORK_W = 2 * MAN_W + 2
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [1:0]        op_i,
    output logic [WORK_W-1:0] x_o,
    output logic [WORK_W-1:0] y_o
);
    import fpadd_pkg::*;

    logic [WORK_W-1:0] ax, bx, a_abs, b_abs;

    assign ax = {a_i[MAN_W], a_i[MAN_W:0], {MAN_W{1'b0}}};
    assign bx = {b_i[MAN_W], b_i[MAN_W:0], {MAN_W{1'b0}}};
    assign a_abs = a_i[MAN_W] ? -ax : ax;
    assign b_abs = b_i[MAN_W] ? -bx : bx;

    always_comb begin
        unique case (op_e'(op_i))
            OP_ADD:    begin x_o = ax;    y_o = bx;     end
            OP_SUB:    begin x_o = ax;    y_o = -bx;    end
            OP_RSUB:   begin x_o = -ax;   y_o = bx;     end
            default:   begin x_o = a_abs; y_o = -b_abs; end
        endcase
    end
endmodule

// File: rtl/fpadd_carry_step.sv
// One carry-settling round: partial sum and shifted carry (R4).
module fpadd_carry_step #(
    parameter int W = 82
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o,
    output logic         settled_o
);
    logic [W-1:0] gen;
    assign gen       = s_i & c_i;
    assign s_o       = s_i ^ c_i;
    assign c_o       = {gen[W-2:0], 1'b0};
    assign settled_o = (c_i == '0);
endmodule

// File: rtl/fpadd_lead_check.sv
// Inspects the top bits of the working mantissa (R5, R7).
module fpadd_lead_check #(
    parameter int W = 82
) (
    input  logic [W-1:0] x_i,
    output logic         ovf_o,
    output logic         normal_o
);
    assign ovf_o    = x_i[W-1] ^ x_i[W-2];
    assign normal_o = x_i[W-2] ^ x_i[W-3];
endmodule

// File: rtl/fpadd_seq.sv
module fpadd_seq #(
    parameter int EXP_W = 7,
    parameter int MAN_W = 40,
    localparam int WORD_W = EXP_W + 1 + MAN_W,
    localparam int WORK_W = 2 * MAN_W + 2,
    localparam int CNT_W  = $clog2(2 * (1 << EXP_W) + WORK_W + 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              norm_en_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic [WORD_W-1:0] opnd_i,
    output logic [WORD_W-1:0] acc_o,
    output logic [MAN_W-1:0]  ext_o,
    output logic              done_o,
    output logic              trap_o,
    output logic [CNT_W-1:0]  cycles_o
);
    import fpadd_pkg::*;

    typedef struct packed {
        state_e            state;
        logic [WORK_W-1:0] x;
        logic [WORK_W-1:0] y;
        logic [EXP_W-1:0]  ex;
        logic [EXP_W-1:0]  ey;
        logic              norm;
        logic [WORD_W-1:0] acc;
        logic [MAN_W-1:0]  ext;
        logic              done;
        logic              trap;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t q, d;

    logic [WORK_W-1:0] prep_x, prep_y, step_s, step_c;
    logic              settled, ovf, normal;
    logic              norm_active;

    fpadd_prep #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_prep (
        .a_i(acc_i), .b_i(opnd_i), .op_i(op_i), .x_o(prep_x), .y_o(prep_y)
    );

    fpadd_carry_step #(.W(WORK_W)) u_step (
        .s_i(q.x), .c_i(q.y), .s_o(step_s), .c_o(step_c), .settled_o(settled)
    );

    fpadd_lead_check #(.W(WORK_W)) u_lead (
        .x_i(q.x), .ovf_o(ovf), .normal_o(normal)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.trap = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (start_i) begin
                    d.x     = prep_x;
                    d.y     = prep_y;
                    d.ex    = acc_i[WORD_W-1:MAN_W+1];
                    d.ey    = opnd_i[WORD_W-1:MAN_W+1];
                    d.norm  = norm_en_i;
                    d.cnt   = '0;
                    d.state = S_ALIGN;
                end
            end
            S_ALIGN: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.ex < q.ey) begin
                    d.x  = {q.x[WORK_W-1], q.x[WORK_W-1:1]};
                    d.ex = q.ex + EXP_W'(1);
                end else if (q.ey < q.ex) begin
                    d.y  = {q.y[WORK_W-1], q.y[WORK_W-1:1]};
                    d.ey = q.ey + EXP_W'(1);
                end else begin
                    d.state = S_ADD;
                end
            end
            S_ADD: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (settled) begin
                    d.state = S_FIX;
                end else begin
                    d.x = step_s;
                    d.y = step_c;
                end
            end
            S_FIX: begin
                d.cnt   = q.cnt + CNT_W'(1);
                d.state = q.norm ? S_NORM : S_WRITE;
                if (ovf) begin
                    if (q.ex == '1) begin
                        d.trap  = 1'b1;
                        d.done  = 1'b1;
                        d.state = S_IDLE;
                    end else begin
                        d.x  = {q.x[WORK_W-1], q.x[WORK_W-1:1]};
                        d.ex = q.ex + EXP_W'(1);
                    end
                end
            end
            S_NORM: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (!normal && q.ex != '0) begin
                    d.x  = {q.x[WORK_W-2:0], 1'b0};
                    d.ex = q.ex - EXP_W'(1);
                end else begin
                    d.state = S_WRITE;
                end
            end
            S_WRITE: begin
                d.cnt   = q.cnt + CNT_W'(1);
                d.acc   = {q.ex, q.x[WORK_W-2:MAN_W]};
                d.ext   = q.x[MAN_W-1:0];
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o       = q.acc;
    assign ext_o       = q.ext;
    assign done_o      = q.done;
    assign trap_o      = q.trap;
    assign cycles_o    = q.cnt;
    assign norm_active = q.norm;
endmodule

// File: rtl/fpadd_seq_chk.sv
module fpadd_seq_chk #(
    parameter int EXP_W = 7,
    parameter int MAN_W = 40,
    parameter int CNT_W = 10,
    localparam int WORD_W = EXP_W + 1 + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] acc_o,
    input logic [MAN_W-1:0]  ext_o,
    input logic              done_o,
    input logic              trap_o,
    input logic [CNT_W-1:0]  cycles_o,
    input logic              norm_active
);
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: accumulator only moves on completion
    a_r10_acc_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_o) |-> done_o);

    // R8: a trap is a completion that keeps the previous result
    a_r8_trap_done: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> done_o);

    a_r8_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($stable(acc_o) && $stable(ext_o)));

    // R5: a normalized result has differing top bits or a zero exponent
    a_r5_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !trap_o && norm_active) |->
        ((acc_o[MAN_W] != acc_o[MAN_W-1]) || (acc_o[WORD_W-1:MAN_W+1] == '0)));

    // R9: every non-trap operation spends at least four clocks
    a_r9_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !trap_o) |-> (cycles_o >= CNT_W'(4)));
endmodule

bind fpadd_seq fpadd_seq_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_o(acc_o), .ext_o(ext_o), .done_o(done_o),
    .trap_o(trap_o), .cycles_o(cycles_o), .norm_active(norm_active)
);

// File: tb/tb_fpadd_seq.sv
module tb_fpadd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        norm_en_i = 1'b0;
    logic [47:0] acc_i = '0;
    logic [47:0] opnd_i = '0;
    logic [47:0] acc_o;
    logic [39:0] ext_o;
    logic        done_o, trap_o;
    logic [9:0]  cycles_o;

    int checks = 0;
    int fails  = 0;
    logic [47:0] m_acc = '0;
    logic [39:0] m_ext = '0;

    always #2 clk = ~clk;

    fpadd_seq dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    function automatic logic signed [81:0] widen(input logic [47:0] w);
        return {w[40], w[40:0], 40'b0};
    endfunction

    // Behavioural reference: value arithmetic and phase counts.
    task automatic model(input logic [47:0] a, input logic [47:0] b, input int op,
                         input bit norm, output logic [47:0] e_acc, output logic [39:0] e_ext,
                         output bit e_trap, output int lat);
        logic signed [81:0] x, y, s, c, t;
        int ea, eb, e, dd, k, n;
        x = widen(a); y = widen(b);
        case (op)
            0: ;
            1: y = -y;
            2: x = -x;
            default: begin
                if (x < 0) x = -x;
                if (y > 0) y = -y;
            end
        endcase
        ea = int'(a[47:41]); eb = int'(b[47:41]);
        if (ea < eb) begin dd = eb - ea; x = x >>> dd; e = eb; end
        else begin dd = ea - eb; y = y >>> dd; e = ea; end
        s = x; c = y; k = 0;
        while (c != 0) begin
            t = s ^ c; c = (s & c) <<< 1; s = t; k++;
        end
        lat = dd + 1 + k + 1 + 1;
        e_trap = 0;
        e_acc = m_acc; e_ext = m_ext;
        if (s[81] != s[80]) begin
            if (e == 127) begin e_trap = 1; return; end
            s = s >>> 1; e++;
        end
        n = 0;
        if (norm) begin
            while (s[80] == s[79] && e != 0) begin s = s <<< 1; e--; n++; end
            lat += n + 1;
        end
        lat += 1;
        e_acc = {7'(e), s[80:40]};
        e_ext = s[39:0];
    endtask

    task automatic run(input string tag, input logic [47:0] a, input logic [47:0] b,
                       input int op, input bit norm);
        logic [47:0] e_acc; logic [39:0] e_ext; bit e_trap; int lat; bit bad;
        model(a, b, op, norm, e_acc, e_ext, e_trap, lat);
        @(negedge clk);
        acc_i = a; opnd_i = b; op_i = 2'(op); norm_en_i = norm; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        bad = 0;
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            if (done_o !== (i == lat)) bad = 1;
        end
        chk({tag, " R10 done timing"}, 64'(bad), 64'd0);
        chk({tag, " R9 cycles"}, 64'(cycles_o), 64'(lat));
        chk({tag, " R8 trap"}, 64'(trap_o), 64'(e_trap));
        chk({tag, " R2 acc"}, 64'(acc_o), 64'(e_acc));
        chk({tag, " R3 ext"}, 64'(ext_o), 64'(e_ext));
        m_acc = e_acc; m_ext = e_ext;
    endtask

    localparam logic [40:0] MINUS_ONE = 41'h100_0000_0000;
    localparam logic [40:0] HALF      = 41'h080_0000_0000;

    initial begin
        #(4 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 acc", 64'(acc_o), 64'd0);
        chk("R1 ext", 64'(ext_o), 64'd0);
        chk("R1 done/trap", 64'({done_o, trap_o}), 64'd0);
        chk("R1 cycles", 64'(cycles_o), 64'd0);
        rst_n = 1'b1;

        // R6 integer addition: equal exponents, normalization off
        run("R6 int add", {7'd64, 41'd5}, {7'd64, 41'd3}, 0, 0);
        chk("R6 int sum", 64'(acc_o), 64'({7'd64, 41'd8}));
        run("R4 carry chain", {7'd64, 41'h0FF_FFFF_FFFF}, {7'd64, 41'd1}, 0, 0);
        // R2 each operation code, with mixed signs
        run("R2 sub", {7'd70, 41'h040_0000_0000}, {7'd66, -41'sd12345}, 1, 1);
        run("R2 rsub", {7'd60, -41'sd999}, {7'd61, 41'h020_0000_0000}, 2, 1);
        run("R2 abssub", {7'd64, -41'sd77777}, {7'd64, 41'h001_0000_0000}, 3, 1);
        // R3 long alignment pushing bits into the extension
        run("R3 align", {7'd90, 41'h040_0000_0000}, {7'd50, -41'sd3}, 0, 0);
        // R5 and R9 zero pair at opposite exponents
        run("R5 zeros", {7'd127, 41'd0}, {7'd0, 41'd0}, 0, 1);
        chk("R9 longest path", 64'(cycles_o), 64'd259);
        chk("R5 zero exp", 64'(acc_o), 64'd0);
        // R3 and R5: sign replication across all 80 bits, then normalization
        run("R3 replicate", {7'd127, 41'd0}, {7'd0, MINUS_ONE}, 0, 1);
        chk("R5 replicate result", 64'(acc_o), 64'({7'd47, MINUS_ONE}));
        chk("R9 replicate cycles", 64'(cycles_o), 64'd213);
        // R7 mantissa overflow
        run("R7 ovf", {7'd10, MINUS_ONE}, {7'd10, MINUS_ONE}, 0, 1);
        chk("R7 ovf result", 64'(acc_o), 64'({7'd11, MINUS_ONE}));
        run("R7 negate", {7'd20, 41'd0}, {7'd20, MINUS_ONE}, 1, 0);
        chk("R7 negate result", 64'(acc_o), 64'({7'd21, HALF}));
        // R8 exponent overflow: trap, previous result kept
        run("R8 trap", {7'd127, MINUS_ONE}, {7'd127, MINUS_ONE}, 0, 1);
        chk("R8 trap held", 64'(acc_o), 64'({7'd21, HALF}));
        // R2 mixed patterns
        for (int i = 0; i < 6; i++) begin
            run("R2 mix", {7'($urandom_range(40, 90)), 41'($urandom)},
                {7'($urandom_range(40, 90)), 41'({$urandom, $urandom})},
                i % 4, (i % 2) == 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule